// File: doc/BRIEF.md
# Prescaled Bus-Stall Timeout Timer

This block is a watchdog for a two-wire bus master. The bus engine asserts a stall-detect input while the clock line is held in a stretched or stalled state. The timer measures how long the stall lasts without a break. When the measured time reaches a programmed limit, the timer raises a sticky timeout flag.

Time is counted in units of the input clock divided by a power of two. Software sets the divider as a log2 exponent in one register. It sets a 15-bit limit and an enable bit together in a single control word. Clearing the enable bit while rewriting the same limit pauses the measurement, and the count collected so far is kept.

Any break in the stall starts the measurement again. A break is the stall input going low, or a pulse on the activity input. Software reads the flag through the register port and clears it by writing 1 to it. The flag feeds an interrupt controller, which is outside this block.

Top module: `bus_stall_timer`

## Requirements
- R1: Register address 0 is the control word. Bit 15 is the enable, bits 14:0 are the limit, and a write reads back unchanged.
- R2: Register address 1 holds the prescaler exponent N in bits 3:0. A written value above 14 is stored as 14, and the count advances once every 2^N clock cycles of continuous, enabled stall.
- R3: With the timer enabled, a non-zero limit L and stall_i held high, timeout_o stays low through the first L*2^N rising edges. It is high after edge L*2^N+1.
- R4: A cycle with stall_i low or activity_i high clears the count and the prescaler phase. Measurement then starts again from zero.
- R5: While the enable bit is 0, the count and the prescaler phase hold their values. Setting the enable bit again resumes counting from the held value.
- R6: Register address 2, bit 0, reads the timeout flag. The flag is sticky. Writing 1 to that bit clears it, and writing 0 has no effect.
- R7: The flag sets at most once per stall episode. If it is cleared while the same stall continues, it stays low.
- R8: A limit of 0 never raises the flag, even with the enable bit set.
- R9: After reset, all registers read 0 and timeout_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 control, 1 exponent, 2 status) |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i |
| stall_i | input | 1 | Bus engine reports the clock line as stalled |
| activity_i | input | 1 | Bus activity seen; restarts the measurement |
| timeout_o | output | 1 | Sticky timeout flag |

## Verification
The assertions assume that stall_i and activity_i are synchronous to clk_i and hold stable values at each rising edge. They also assume that a register write lasts exactly one cycle. The bench changes every input on the falling edge, so these conditions always hold. Each write task raises the strobe for a single cycle. The bench drives stall episodes of chosen length directly and never lets a limit change in the middle of an episode. Under these conditions the pause and restart properties have a single, defined meaning.

// File: rtl/stall_timer_pkg.sv
package stall_timer_pkg;
  localparam int unsigned LIMIT_W = 15;
  localparam int unsigned EXP_W   = 4;
  localparam int unsigned EXP_MAX = 14;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned DATA_W  = LIMIT_W + 1;
  localparam int unsigned PRE_W   = EXP_MAX + 1;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_EXP  = 2'd1,
    ADDR_STAT = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/stall_timer_regs.sv
module stall_timer_regs
  import stall_timer_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic               set_flag_i,
  output logic               en_o,
  output logic [LIMIT_W-1:0] limit_o,
  output logic [EXP_W-1:0]   exp_o,
  output logic               flag_o
);
  logic               en_q, flag_q;
  logic [LIMIT_W-1:0] limit_q;
  logic [EXP_W-1:0]   exp_q, exp_wr;
  logic               wr_ctrl, wr_exp, clr_flag;
  logic               unused_wdata;

  assign unused_wdata = ^reg_wdata_i;
  assign wr_ctrl  = reg_we_i && (reg_addr_i == ADDR_CTRL);
  assign wr_exp   = reg_we_i && (reg_addr_i == ADDR_EXP);
  assign clr_flag = reg_we_i && (reg_addr_i == ADDR_STAT) && reg_wdata_i[0];

  // exponent beyond the supported range saturates
  assign exp_wr = (reg_wdata_i[EXP_W-1:0] > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX)
                                                             : reg_wdata_i[EXP_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      limit_q <= '0;
      exp_q   <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q    <= reg_wdata_i[LIMIT_W];
        limit_q <= reg_wdata_i[LIMIT_W-1:0];
      end
      if (wr_exp) exp_q <= exp_wr;
      // set has priority over a simultaneous clear
      flag_q <= set_flag_i || (flag_q && !clr_flag);
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CTRL: reg_rdata_o = {en_q, limit_q};
      ADDR_EXP:  reg_rdata_o = {{(DATA_W-EXP_W){1'b0}}, exp_q};
      ADDR_STAT: reg_rdata_o = {{(DATA_W-1){1'b0}}, flag_q};
      default:   reg_rdata_o = '0;
    endcase
  end

  assign en_o    = en_q;
  assign limit_o = limit_q;
  assign exp_o   = exp_q;
  assign flag_o  = flag_q;
endmodule

// File: rtl/stall_timer_prescaler.sv
module stall_timer_prescaler
  import stall_timer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_q, mask;

  assign mask   = (PRE_W'(1) << exp_i) - PRE_W'(1);
  assign tick_o = run_i && (pre_q == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pre_q <= '0;
    else if (restart_i) pre_q <= '0;
    else if (tick_o)    pre_q <= '0;
    else if (run_i)     pre_q <= pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/stall_timer_counter.sv
module stall_timer_counter
  import stall_timer_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  input  logic               run_i,
  input  logic               tick_i,
  input  logic [LIMIT_W-1:0] limit_i,
  output logic [LIMIT_W-1:0] cnt_o,
  output logic               hit_o
);
  logic [LIMIT_W-1:0] cnt_q;
  logic               fired_q;

  // zero limit disables firing; one hit per episode
  assign hit_o = run_i && !fired_q && (limit_i != '0) && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else begin
      if (hit_o) fired_q <= 1'b1;
      else if (tick_i && !fired_q) cnt_q <= cnt_q + LIMIT_W'(1);
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/bus_stall_timer.sv
module bus_stall_timer
  import stall_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              stall_i,
  input  logic              activity_i,
  output logic              timeout_o
);
  logic               en, hit, tick, restart, run;
  logic [LIMIT_W-1:0] limit, cnt;
  logic [EXP_W-1:0]   exp_n;

  assign restart = !stall_i || activity_i;
  assign run     = en && !restart;

  stall_timer_regs i_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .set_flag_i(hit), .en_o(en), .limit_o(limit), .exp_o(exp_n), .flag_o(timeout_o)
  );

  stall_timer_prescaler i_presc (
    .clk_i, .rst_ni, .restart_i(restart), .run_i(run), .exp_i(exp_n), .tick_o(tick)
  );

  stall_timer_counter i_cnt (
    .clk_i, .rst_ni, .restart_i(restart), .run_i(run), .tick_i(tick),
    .limit_i(limit), .cnt_o(cnt), .hit_o(hit)
  );
endmodule

// File: rtl/stall_timer_checker.sv
module stall_timer_checker
  import stall_timer_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_we_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic [DATA_W-1:0]  reg_wdata_i,
  input logic               stall_i,
  input logic               activity_i,
  input logic               timeout_o,
  input logic               en_i,
  input logic [LIMIT_W-1:0] limit_i,
  input logic [EXP_W-1:0]   exp_i,
  input logic [LIMIT_W-1:0] cnt_i
);
  logic clr;
  assign clr = reg_we_i && (reg_addr_i == ADDR_STAT) && reg_wdata_i[0];

  always_comb begin
    if (rst_ni) assert_exp_range_R2: assert (exp_i <= EXP_W'(EXP_MAX));
  end

  assert_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i || activity_i) |=> (cnt_i == '0));

  assert_pause_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && stall_i && !activity_i) |=> $stable(cnt_i));

  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && !clr) |=> timeout_o);

  assert_set_in_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> $past(stall_i && !activity_i && en_i));

  assert_zero_limit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> ($past(limit_i) != '0));
endmodule

bind bus_stall_timer stall_timer_checker i_chk (
  .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .stall_i, .activity_i,
  .timeout_o, .en_i(en), .limit_i(limit), .exp_i(exp_n), .cnt_i(cnt)
);

// File: tb/test_bus_stall_timer.sv
module test_bus_stall_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        stall = 1'b0;
  logic        act = 1'b0;
  logic        tmo;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_stall_timer i_bus_stall_timer (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .stall_i(stall),
    .activity_i(act), .timeout_o(tmo)
  );

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    we = 1'b1; addr = a; wdata = d;
    step(1);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic end_episode();
    stall = 1'b0; act = 1'b0;
    step(2);
    wr(2'd2, 16'h0001);
  endtask

  // checks that the flag rises exactly after n+1 stalled edges
  task automatic expect_fire(input int n, input string req);
    step(n);
    chk(tmo == 1'b0, req, tmo, 0);
    step(1);
    chk(tmo == 1'b1, req, tmo, 1);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk(tmo == 1'b0, "R9 timeout_o", tmo, 0);
    rd(2'd0, d); chk(d == 0, "R9 ctrl", d, 0);
    rd(2'd1, d); chk(d == 0, "R9 exp", d, 0);
    rd(2'd2, d); chk(d == 0, "R9 status", d, 0);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr(2'd0, 16'hA5C3); rd(2'd0, d); chk(d == 16'hA5C3, "R1 ctrl readback", d, 16'hA5C3);
    wr(2'd1, 16'd9);    rd(2'd1, d); chk(d == 16'd9, "R2 exp readback", d, 9);
    wr(2'd1, 16'd15);   rd(2'd1, d); chk(d == 16'd14, "R2 exp clamp", d, 14);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_basic();
    wr(2'd1, 16'd0); wr(2'd0, 16'h8005);
    stall = 1'b1;
    expect_fire(5, "R3 exp0 L5");
    end_episode();
    wr(2'd1, 16'd2); wr(2'd0, 16'h8003);
    stall = 1'b1;
    expect_fire(12, "R2 R3 exp2 L3");
    end_episode();
  endtask

  task automatic t_restart();
    wr(2'd1, 16'd0); wr(2'd0, 16'h8004);
    stall = 1'b1; step(3);
    stall = 1'b0; step(1); stall = 1'b1;
    expect_fire(4, "R4 stall break");
    end_episode();
    stall = 1'b1; step(3);
    act = 1'b1; step(1); act = 1'b0;
    expect_fire(4, "R4 activity");
    end_episode();
  endtask

  task automatic t_pause();
    logic [15:0] d;
    wr(2'd1, 16'd0); wr(2'd0, 16'h8006);
    stall = 1'b1; step(3);
    wr(2'd0, 16'h0006);           // edge still counted: count 4
    rd(2'd0, d); chk(d == 16'h0006, "R5 limit kept", d, 6);
    step(10);
    chk(tmo == 1'b0, "R5 paused", tmo, 0);
    wr(2'd0, 16'h8006);           // edge not counted
    expect_fire(2, "R5 resume");
    end_episode();
  endtask

  task automatic t_sticky();
    logic [15:0] d;
    wr(2'd1, 16'd0); wr(2'd0, 16'h8002);
    stall = 1'b1; step(3);
    stall = 1'b0; step(5);
    chk(tmo == 1'b1, "R6 sticky", tmo, 1);
    wr(2'd2, 16'h0000);
    rd(2'd2, d); chk(d == 16'd1, "R6 write 0 ignored", d, 1);
    wr(2'd2, 16'h0001);
    rd(2'd2, d); chk(d == 16'd0, "R6 write 1 clears", d, 0);
    stall = 1'b1; step(3);
    chk(tmo == 1'b1, "R7 fired", tmo, 1);
    wr(2'd2, 16'h0001);
    step(20);
    chk(tmo == 1'b0, "R7 once per episode", tmo, 0);
    end_episode();
  endtask

  task automatic t_zero();
    wr(2'd1, 16'd0); wr(2'd0, 16'h8000);
    stall = 1'b1; step(300);
    chk(tmo == 1'b0, "R8 zero limit", tmo, 0);
    end_episode();
  endtask

  task automatic t_max_exp();
    wr(2'd1, 16'd15); wr(2'd0, 16'h8001);
    stall = 1'b1;
    expect_fire(16384, "R2 clamped exp14 L1");
    end_episode();
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_regs();
    t_basic();
    t_restart();
    t_pause();
    t_sticky();
    t_zero();
    t_max_exp();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule